// File: doc/BRIEF.md
# Cascaded Programmable Interrupt Controller

The block gathers sixteen level-sensitive interrupt request lines into two eight-line controller units, a master (lines 0 to 7) and a slave (lines 8 to 15), and drives a single interrupt output toward a CPU. Each unit has a command port and a data port on a byte-wide register bus. The master answers at addresses 0x20 (command) and 0x21 (data); the slave answers at 0xA0 (command) and 0xA1 (data). The bus ignores any other address, and reads of such addresses return zero. Reads have no side effects and are combinational from the address.

Each line has a mask bit, a request bit and an in-service bit. Both units share one global priority order. From highest to lowest it is 0, 1, 8 to 15, then 2 to 7, so the slave sits nested at master line 2. The block raises `int_out` for the best unmasked request, but only when that request outranks every line already in service. It then presents that line's vector. An acknowledge moves the line into service, unless the owning unit has automatic end-of-interrupt (EOI) enabled.

Each unit contains a configuration state machine with four states:
- `CS_READY`: data writes load the mask.
- `CS_BASE`: the next data write sets the vector base.
- `CS_CASCADE`: the next data write is taken and discarded.
- `CS_MODE`: the next data write sets the EOI mode.

Its transitions are:
- `go_init`: command 0x10 or 0x11 from any state goes to `CS_BASE`.
- `take_base`: `CS_BASE` goes to `CS_CASCADE`.
- `end_short`: `CS_CASCADE` goes to `CS_READY` after 0x10.
- `to_mode`: `CS_CASCADE` goes to `CS_MODE` after 0x11.
- `end_long`: `CS_MODE` goes to `CS_READY`.
- `stay_ready`: a mask load keeps the unit in `CS_READY`.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset the master mask reads 0xFC and the slave mask reads 0xEE. Vectors are 0x08+n for master line n and 0x70+(n-8) for slave line n. Reads of the command ports return the request register. Automatic EOI is off. With no request pending, `int_out` is low.
- R2: A write of 0x0B to a command port makes reads of that port return that unit's in-service byte. A write of 0x0A makes them return its request byte. A read of a data port returns that unit's mask. In every byte, bit k is the unit's line k.
- R3: Command 0x10 starts a two-word initialization sequence and command 0x11 starts a three-word sequence. The first data word sets the unit's vector base to the word with bits 2:0 cleared, and line k's vector is that base plus k. The mask is unchanged until the sequence ends, and the next data write then loads the mask.
- R4: Bit 1 of the third word of a three-word sequence enables automatic EOI for that unit. An acknowledged line of such a unit does not enter service.
- R5: In `CS_READY`, a data write loads the mask, where bit k set masks line k. A masked line never causes `int_out`.
- R6: `int_vector` is the vector of the unmasked requesting line highest in the order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 2, 3, 4, 5, 6, 7.
- R7: `int_out` is high only when the best request outranks every line in service. The active line is the highest-ranked line in service.
- R8: `int_ack` while `int_out` is high puts the presented line into service. `int_ack` while `int_out` is low changes nothing.
- R9: Commands 0x20 to 0x27 clear the active line's in-service bit when that line belongs to the written unit, and otherwise have no effect.
- R10: Commands 0x60+n (n from 0 to 7) clear line n of the written unit only when that line is the active line.
- R11: Commands 0xC0 to 0xC7 are accepted without effect. Any command byte outside the accepted set raises `cmd_reject` during its write cycle and changes no state.
- R12: The request register samples `irq_req` on each clock edge, so a request shows one edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cmd_reject | output | 1 | Unsupported command byte being written |
| irq_req | input | 16 | Level interrupt requests, bit n is line n |
| int_out | output | 1 | Interrupt request to the CPU |
| int_vector | output | 8 | Vector of the presented line |
| int_ack | input | 1 | CPU acknowledge |

## Verification
The hardest state to reach is a three-deep nest in which a slave line is active above two master lines. In that state an EOI on the master port must do nothing, and a specific EOI naming a master line that is not the active line must also do nothing. The bench builds this nest by raising requests in rising priority order. It acknowledges each one, then drops all requests, so that only the in-service bits decide the outcome. It then unwinds the nest with a mix of specific and nonspecific EOIs and reads the in-service bytes after each step.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
    localparam int LINES_PER_UNIT = 8;
    localparam int NUM_UNITS      = 2;
    localparam int TOTAL_LINES    = LINES_PER_UNIT * NUM_UNITS;
    localparam int LINE_W         = $clog2(TOTAL_LINES);
    localparam int SUB_W          = $clog2(LINES_PER_UNIT);
    localparam int BYTE_W         = 8;
    localparam int MASTER_TOP     = 2;   // lines ranked above the slave group
    localparam int SLAVE_HOOK     = 2;   // master line the slave nests at

    localparam logic [BYTE_W-1:0] CMD_SEL_IRR  = 8'h0A;
    localparam logic [BYTE_W-1:0] CMD_SEL_ISR  = 8'h0B;
    localparam logic [BYTE_W-1:0] CMD_INIT_2   = 8'h10;
    localparam logic [BYTE_W-1:0] CMD_INIT_3   = 8'h11;
    localparam logic [4:0]        GRP_EOI_ANY  = 5'b00100;
    localparam logic [4:0]        GRP_EOI_ONE  = 5'b01100;
    localparam logic [4:0]        GRP_PRIO     = 5'b11000;

    typedef enum logic [1:0] {
        CS_READY,
        CS_BASE,
        CS_CASCADE,
        CS_MODE
    } cfg_state_e;

    // global rank (0 = highest) to line number
    function automatic logic [LINE_W-1:0] rank_to_line(input logic [LINE_W-1:0] r);
        if (int'(r) < MASTER_TOP)
            return r;
        else if (int'(r) < MASTER_TOP + LINES_PER_UNIT)
            return LINE_W'(int'(r) - MASTER_TOP + LINES_PER_UNIT);
        else
            return LINE_W'(int'(r) - LINES_PER_UNIT);
    endfunction
endpackage

// File: rtl/cpic_resolver.sv
module cpic_resolver
    import cpic_pkg::*;
(
    input  logic [TOTAL_LINES-1:0] req,
    output logic                   hit,
    output logic [LINE_W-1:0]      line,
    output logic [LINE_W-1:0]      rank
);
    always_comb begin
        hit  = 1'b0;
        line = '0;
        rank = '0;
        // scan lowest priority first so the highest one wins
        for (int r = TOTAL_LINES - 1; r >= 0; r--) begin
            if (req[rank_to_line(LINE_W'(r))]) begin
                hit  = 1'b1;
                line = rank_to_line(LINE_W'(r));
                rank = LINE_W'(r);
            end
        end
    end
endmodule

// File: rtl/cpic_unit_regs.sv
module cpic_unit_regs
    import cpic_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_MASK = 8'hFF,
    parameter logic [BYTE_W-1:0] RESET_BASE = 8'h08
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic                 data_wr,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [BYTE_W-1:0]    mask,
    output logic [BYTE_W-1:0]    base,
    output logic                 auto_eoi,
    output logic                 sel_isr,
    output logic                 eoi_any,
    output logic                 eoi_one,
    output logic [SUB_W-1:0]     eoi_sub,
    output logic                 reject,
    output cfg_state_e           state
);
    cfg_state_e              state_nx;
    logic                    long_seq;
    logic [BYTE_W-1:SUB_W]   base_hi;
    logic                    is_init, is_sel, is_prio;

    // command decode
    always_comb begin
        is_init = (wr_data == CMD_INIT_2) || (wr_data == CMD_INIT_3);
        is_sel  = (wr_data == CMD_SEL_IRR) || (wr_data == CMD_SEL_ISR);
        is_prio = (wr_data[7:3] == GRP_PRIO);
        eoi_any = cmd_wr && (wr_data[7:3] == GRP_EOI_ANY);
        eoi_one = cmd_wr && (wr_data[7:3] == GRP_EOI_ONE);
        eoi_sub = wr_data[SUB_W-1:0];
        reject  = cmd_wr && !(is_init || is_sel || is_prio ||
                              (wr_data[7:3] == GRP_EOI_ANY) ||
                              (wr_data[7:3] == GRP_EOI_ONE));
    end

    // next state
    always_comb begin
        state_nx = state;
        if (cmd_wr && is_init) begin
            state_nx = CS_BASE;                              // go_init
        end else if (data_wr) begin
            unique case (state)
                CS_READY:   state_nx = CS_READY;             // stay_ready
                CS_BASE:    state_nx = CS_CASCADE;           // take_base
                CS_CASCADE: state_nx = long_seq ? CS_MODE    // to_mode
                                                : CS_READY;  // end_short
                CS_MODE:    state_nx = CS_READY;             // end_long
                default:    state_nx = CS_READY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CS_READY;
        else        state <= state_nx;
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask     <= RESET_MASK;
            base_hi  <= RESET_BASE[BYTE_W-1:SUB_W];
            auto_eoi <= 1'b0;
            sel_isr  <= 1'b0;
            long_seq <= 1'b0;
        end else begin
            if (cmd_wr && is_init)
                long_seq <= (wr_data == CMD_INIT_3);
            if (cmd_wr && is_sel)
                sel_isr <= (wr_data == CMD_SEL_ISR);
            if (data_wr) begin
                unique case (state)
                    CS_READY:   mask     <= wr_data;
                    CS_BASE:    base_hi  <= wr_data[BYTE_W-1:SUB_W];
                    CS_CASCADE: ;
                    CS_MODE:    auto_eoi <= wr_data[1];
                    default:    ;
                endcase
            end
        end
    end

    assign base = {base_hi, {SUB_W{1'b0}}};
endmodule

// File: rtl/cpic_service.sv
module cpic_service
    import cpic_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                set_en,
    input  logic [LINE_W-1:0]                   set_line,
    input  logic [NUM_UNITS-1:0]                eoi_any,
    input  logic [NUM_UNITS-1:0]                eoi_one,
    input  logic [NUM_UNITS-1:0][SUB_W-1:0]     eoi_sub,
    output logic [TOTAL_LINES-1:0]              isr,
    output logic                                act_hit,
    output logic [LINE_W-1:0]                   act_line,
    output logic [LINE_W-1:0]                   act_rank
);
    logic [NUM_UNITS-1:0][TOTAL_LINES-1:0] clr_unit;
    logic [TOTAL_LINES-1:0]                clr_all;
    logic [TOTAL_LINES-1:0]                set_vec;

    cpic_resolver u_active (
        .req  (isr),
        .hit  (act_hit),
        .line (act_line),
        .rank (act_rank)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit_eoi
        logic owns;
        logic match;
        assign owns  = act_hit && (int'(act_line[LINE_W-1]) == u);
        assign match = owns && (act_line[SUB_W-1:0] == eoi_sub[u]);
        always_comb begin
            clr_unit[u] = '0;
            if ((eoi_any[u] && owns) || (eoi_one[u] && match))
                clr_unit[u][act_line] = 1'b1;
        end
    end

    always_comb begin
        clr_all = '0;
        for (int u = 0; u < NUM_UNITS; u++)
            clr_all = clr_all | clr_unit[u];
        set_vec = '0;
        if (set_en)
            set_vec[set_line] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~clr_all) | set_vec;
    end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
    import cpic_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MASTER_ADDR  = 8'h20,
    parameter logic [BYTE_W-1:0] SLAVE_ADDR   = 8'hA0,
    parameter logic [BYTE_W-1:0] MASTER_MASK0 = 8'hFC,
    parameter logic [BYTE_W-1:0] SLAVE_MASK0  = 8'hEE,
    parameter logic [BYTE_W-1:0] MASTER_BASE0 = 8'h08,
    parameter logic [BYTE_W-1:0] SLAVE_BASE0  = 8'h70
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BYTE_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic [BYTE_W-1:0]      bus_wdata,
    output logic [BYTE_W-1:0]      bus_rdata,
    output logic                   cmd_reject,
    input  logic [TOTAL_LINES-1:0] irq_req,
    output logic                   int_out,
    output logic [BYTE_W-1:0]      int_vector,
    input  logic                   int_ack
);
    localparam logic [BYTE_W-1:0] UNIT_ADDR [NUM_UNITS] = '{MASTER_ADDR, SLAVE_ADDR};
    localparam logic [BYTE_W-1:0] UNIT_MASK [NUM_UNITS] = '{MASTER_MASK0, SLAVE_MASK0};
    localparam logic [BYTE_W-1:0] UNIT_BASE [NUM_UNITS] = '{MASTER_BASE0, SLAVE_BASE0};

    logic [TOTAL_LINES-1:0]             irr_q;
    logic [NUM_UNITS-1:0][BYTE_W-1:0]   mask_u, base_u;
    logic [NUM_UNITS-1:0]               aeoi_u, sel_isr_u, eoi_any_u, eoi_one_u, rej_u;
    logic [NUM_UNITS-1:0][SUB_W-1:0]    eoi_sub_u;
    logic [NUM_UNITS-1:0]               hit_cmd, hit_data;
    cfg_state_e                         state_u [NUM_UNITS];
    logic [TOTAL_LINES-1:0]             mask_all, pending, isr;
    logic                               best_hit, act_hit;
    logic [LINE_W-1:0]                  best_line, best_rank, act_line, act_rank;
    logic                               best_unit, ack_take, ack_auto;

    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= irq_req;
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        assign hit_cmd[u]  = bus_addr == UNIT_ADDR[u];
        assign hit_data[u] = bus_addr == (UNIT_ADDR[u] | 8'h01);

        cpic_unit_regs #(
            .RESET_MASK (UNIT_MASK[u]),
            .RESET_BASE (UNIT_BASE[u])
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_wr   (bus_wr && hit_cmd[u]),
            .data_wr  (bus_wr && hit_data[u]),
            .wr_data  (bus_wdata),
            .mask     (mask_u[u]),
            .base     (base_u[u]),
            .auto_eoi (aeoi_u[u]),
            .sel_isr  (sel_isr_u[u]),
            .eoi_any  (eoi_any_u[u]),
            .eoi_one  (eoi_one_u[u]),
            .eoi_sub  (eoi_sub_u[u]),
            .reject   (rej_u[u]),
            .state    (state_u[u])
        );

        assign mask_all[u*LINES_PER_UNIT +: LINES_PER_UNIT] = mask_u[u];
    end

    assign pending = irr_q & ~mask_all;

    cpic_resolver u_best (
        .req  (pending),
        .hit  (best_hit),
        .line (best_line),
        .rank (best_rank)
    );

    cpic_service u_service (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (ack_take && !ack_auto),
        .set_line (best_line),
        .eoi_any  (eoi_any_u),
        .eoi_one  (eoi_one_u),
        .eoi_sub  (eoi_sub_u),
        .isr      (isr),
        .act_hit  (act_hit),
        .act_line (act_line),
        .act_rank (act_rank)
    );

    always_comb begin
        best_unit  = best_line[LINE_W-1];
        int_out    = best_hit && (!act_hit || (best_rank < act_rank));
        int_vector = base_u[best_unit] | BYTE_W'(best_line[SUB_W-1:0]);
        ack_take   = int_ack && int_out;
        ack_auto   = aeoi_u[best_unit];
        cmd_reject = |rej_u;
    end

    always_comb begin
        bus_rdata = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (hit_cmd[u])
                bus_rdata = sel_isr_u[u] ? isr[u*LINES_PER_UNIT +: LINES_PER_UNIT]
                                         : irr_q[u*LINES_PER_UNIT +: LINES_PER_UNIT];
            else if (hit_data[u])
                bus_rdata = mask_u[u];
        end
    end
endmodule

// File: rtl/cpic_checker.sv
module cpic_checker
    import cpic_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   int_out,
    input logic                   int_ack,
    input logic [LINE_W-1:0]      best_line,
    input logic                   ack_auto,
    input logic [TOTAL_LINES-1:0] isr,
    input logic [TOTAL_LINES-1:0] mask_all,
    input logic                   cmd_reject,
    input cfg_state_e             state_m,
    input cfg_state_e             state_s
);
    assert_ack_enters_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && !ack_auto) |=> isr[$past(best_line)]);

    assert_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_out) |=> ((isr & ~$past(isr)) == '0));

    assert_auto_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && ack_auto) |=> !isr[$past(best_line)]);

    assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> !mask_all[best_line]);

    assert_no_reentry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> !isr[best_line]);

    assert_reject_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |=> ($stable(state_m) && $stable(state_s)));
endmodule

bind cascade_irq_ctrl cpic_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_out    (int_out),
    .int_ack    (int_ack),
    .best_line  (best_line),
    .ack_auto   (ack_auto),
    .isr        (isr),
    .mask_all   (mask_all),
    .cmd_reject (cmd_reject),
    .state_m    (state_u[0]),
    .state_s    (state_u[1])
);

// File: tb/cascade_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        cmd_reject;
    logic [15:0] irq_req = '0;
    logic        int_out;
    logic [7:0]  int_vector;
    logic        int_ack = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cascade_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_reject(cmd_reject),
        .irq_req(irq_req), .int_out(int_out), .int_vector(int_vector),
        .int_ack(int_ack)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_rej(input logic [7:0] a, input logic [7:0] d, input bit exp);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 check("R11 cmd_reject", int'(cmd_reject), int'(exp));
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string req);
        bus_addr = a;
        #1 check(req, int'(bus_rdata), exp);
    endtask

    task automatic set_irq(input logic [15:0] v);
        @(negedge clk);
        irq_req = v;
        @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic t_reset();
        rd(8'h21, 8'hFC, "R1 master mask");
        rd(8'hA1, 8'hEE, "R1 slave mask");
        rd(8'h20, 8'h00, "R1 irr select");
        check("R1 int_out idle", int'(int_out), 0);
        set_irq(16'h1000);
        check("R1 slave vector", int'(int_vector), 8'h74);
        set_irq(16'h1101);
        check("R6 default vector", int'(int_vector), 8'h08);
        set_irq(16'h0000);
    endtask

    task automatic t_latency();
        @(negedge clk);
        irq_req = 16'h0008;
        rd(8'h20, 8'h00, "R12 before edge");
        @(negedge clk);
        rd(8'h20, 8'h08, "R12 after edge");
        check("R5 masked quiet", int'(int_out), 0);
        set_irq(16'h0000);
    endtask

    task automatic t_select_reject();
        wr(8'h21, 8'hFF);
        set_irq(16'h0010);
        wr_rej(8'h20, 8'h0B, 1'b0);
        rd(8'h20, 8'h00, "R2 isr view");
        wr_rej(8'h20, 8'hC5, 1'b0);
        rd(8'h20, 8'h00, "R11 prio ignored");
        wr_rej(8'h20, 8'h99, 1'b1);
        rd(8'h20, 8'h00, "R11 reject no change");
        wr_rej(8'h20, 8'h0A, 1'b0);
        rd(8'h20, 8'h10, "R2 irr view");
        check("R5 masked line", int'(int_out), 0);
        set_irq(16'h0000);
    endtask

    task automatic t_priority();
        wr(8'h21, 8'h00);
        wr(8'hA1, 8'h00);
        rd(8'h21, 8'h00, "R5 mask load");
        set_irq(16'h0204);
        check("R6 slave over 2", int'(int_vector), 8'h71);
        set_irq(16'h0088);
        check("R6 3 over 7", int'(int_vector), 8'h0B);
        set_irq(16'h0102);
        check("R6 1 over 8", int'(int_vector), 8'h09);
        set_irq(16'h8080);
        check("R6 15 over 7", int'(int_vector), 8'h77);
        set_irq(16'h0000);
    endtask

    task automatic t_mask();
        wr(8'hA1, 8'h02);
        set_irq(16'h0220);
        check("R5 masked skipped", int'(int_vector), 8'h0D);
        set_irq(16'h0200);
        check("R5 masked alone", int'(int_out), 0);
        wr(8'hA1, 8'h00);
        set_irq(16'h0000);
    endtask

    task automatic t_ack_ignored();
        ack();
        wr(8'h20, 8'h0B);
        wr(8'hA0, 8'h0B);
        rd(8'h20, 8'h00, "R8 ignored ack master");
        rd(8'hA0, 8'h00, "R8 ignored ack slave");
    endtask

    task automatic t_nest_eoi();
        set_irq(16'h0020);
        check("R7 first", int'(int_out), 1);
        check("R6 line5", int'(int_vector), 8'h0D);
        ack();
        rd(8'h20, 8'h20, "R8 line5 in service");
        check("R7 no self nest", int'(int_out), 0);
        set_irq(16'h0060);
        check("R7 lower blocked", int'(int_out), 0);
        set_irq(16'h0068);
        check("R7 higher nests", int'(int_out), 1);
        check("R6 line3", int'(int_vector), 8'h0B);
        ack();
        rd(8'h20, 8'h28, "R8 line3 in service");
        set_irq(16'h0468);
        check("R7 slave nests", int'(int_vector), 8'h72);
        ack();
        rd(8'hA0, 8'h04, "R8 line10 in service");
        set_irq(16'h0000);
        check("R7 idle", int'(int_out), 0);
        wr(8'h20, 8'h63);
        rd(8'h20, 8'h28, "R10 not active");
        wr(8'h20, 8'h20);
        rd(8'h20, 8'h28, "R9 other unit");
        wr(8'hA0, 8'h62);
        rd(8'hA0, 8'h00, "R10 specific clears");
        wr(8'h20, 8'h21);
        rd(8'h20, 8'h20, "R9 clears line3");
        wr(8'h20, 8'h65);
        rd(8'h20, 8'h00, "R10 clears line5");
    endtask

    task automatic t_init_short();
        wr(8'h21, 8'hF7);
        wr(8'h20, 8'h10);
        wr(8'h21, 8'h45);
        rd(8'h21, 8'hF7, "R3 mask held base");
        wr(8'h21, 8'h00);
        rd(8'h21, 8'hF7, "R3 mask held cascade");
        wr(8'h21, 8'hE7);
        rd(8'h21, 8'hE7, "R3 two words then mask");
        set_irq(16'h0008);
        check("R3 new base", int'(int_vector), 8'h43);
        ack();
        rd(8'h20, 8'h08, "R3 normal eoi mode");
        set_irq(16'h0000);
        wr(8'h20, 8'h20);
        rd(8'h20, 8'h00, "R9 clear");
    endtask

    task automatic t_init_long();
        wr(8'hA0, 8'h11);
        wr(8'hA1, 8'h2F);
        wr(8'hA1, 8'h02);
        rd(8'hA1, 8'h00, "R3 long after two");
        wr(8'hA1, 8'h02);
        rd(8'hA1, 8'h00, "R3 third word not mask");
        wr(8'hA1, 8'hF7);
        rd(8'hA1, 8'hF7, "R3 mask after three");
        set_irq(16'h0800);
        check("R3 slave base", int'(int_vector), 8'h2B);
        ack();
        rd(8'hA0, 8'h00, "R4 auto eoi");
        check("R4 request again", int'(int_out), 1);
        set_irq(16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_select_reject();
        t_priority();
        t_mask();
        t_ack_ignored();
        t_nest_eoi();
        t_init_short();
        t_init_long();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule